// File: doc/BRIEF.md
# Dual-Rail Ripple Adder Block with Zero Carry-In

This block adds two operand slices with the carry input held at zero. The caller supplies the per-bit propagate terms, already formed and checked by logic outside the block. The block produces three things: the true sum, an inverted sum that is worked out separately, and two copies of the carry output. It is meant to be one slice of a self-checking carry-select adder. A later selection stage and a checker compare the true and inverted rails, and the next slice consumes the two carry copies on separate paths.

Inside, two ripple carry chains run side by side. Each chain forms its own generate terms from the operand bits. One chain drives only the true sum and the first carry copy. The other drives only the inverted sum and the second carry copy. A single fault inside one chain can therefore corrupt at most one rail. Each chain alternates its cell type from bit to bit. An even cell takes a true carry and passes on an inverted carry through one AND-OR-invert gate. An odd cell takes the inverted carry and passes on a true carry through one OR-AND-invert gate. The carry polarity therefore flips at every bit, and each stage costs a single inverting gate.

Top module: `sdAdderBlock`

## Requirements
- R1: When `propIn` equals `opA ^ opB`, the value `{carryOutA, sumOut}` equals `opA + opB` with no carry input.
- R2: `sumInvOut` is the bitwise complement of `sumOut` for every input pattern, including patterns where `propIn` does not match the operands.
- R3: `carryOutA` and `carryOutB` are equal for every input pattern.
- R4: The carry input is zero. Bit 0 of `sumOut` equals `propIn[0]`. When every propagate bit is 1 and no bit position has both operand bits set, `sumOut` is all ones and both carry outputs are 0.
- R5: The propagate input is used exactly as supplied and is never recomputed from the operands. For each bit i, sum bit i equals `propIn[i]` XOR carry i. Carry i+1 equals `(opA[i] & opB[i]) | (propIn[i] & carry i)`, with carry 0 equal to 0.
- R6: A carry raised at bit 0 ripples through the whole slice. With `opA` all ones, `opB` equal to 1 and consistent propagate terms, `sumOut` is 0 and both carry outputs are 1.
- R7: The same behaviour holds for slice widths of 8 and of 12 bits, selected by the `WIDTH` parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | WIDTH | First operand slice |
| opB | input | WIDTH | Second operand slice |
| propIn | input | WIDTH | Propagate terms supplied from outside the block |
| sumOut | output | WIDTH | True sum rail |
| sumInvOut | output | WIDTH | Inverted sum rail, from the second carry chain |
| carryOutA | output | 1 | Carry output, copy from the first chain |
| carryOutB | output | 1 | Carry output, copy from the second chain |

## Verification
Four properties are checked on every input change:
- the complement relation between the two rails;
- agreement of the two carry copies;
- the arithmetic sum whenever the propagate terms match the operands;
- the bit-0 and all-propagate behaviour that follows from the zero carry input.

Other behaviours can only be shown by the bench's scenarios. These are the exact result when the propagate input deliberately disagrees with the operands, the full-length ripple, and equal behaviour at a second width. The bench covers them by comparing both instances against a behavioural bit-serial model on every clock.

// File: rtl/sdPkg.sv
package sdPkg;
  localparam int SD_DEF_WIDTH = 8;

  // Cell variant for bit position: even cells take a true carry,
  // odd cells take an inverted one.
  function automatic bit cellIsEven(input int pos);
    return (pos % 2) == 0;
  endfunction
endpackage

// File: rtl/sdGenStage.sv
module sdGenStage #(
  parameter int WIDTH = sdPkg::SD_DEF_WIDTH
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] genOut
);
  // Private generate terms for one carry chain.
  always_comb genOut = opA & opB;
endmodule

// File: rtl/sdRailChain.sv
module sdRailChain #(
  parameter int WIDTH    = sdPkg::SD_DEF_WIDTH,
  parameter bit INV_RAIL = 1'b0
) (
  input  logic [WIDTH-1:0] propIn,
  input  logic [WIDTH-1:0] genIn,
  output logic [WIDTH-1:0] railOut,
  output logic             carryOut
);
  // carryNet[i]: true carry when i is even, inverted carry when i is odd.
  logic [WIDTH:0] carryNet;

  assign carryNet[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : gCell
    if (sdPkg::cellIsEven(i)) begin : gEven
      // AND-OR-invert: passes on the inverted carry.
      assign carryNet[i+1] = ~(genIn[i] | (propIn[i] & carryNet[i]));
      if (INV_RAIL) begin : gInv
        assign railOut[i] = ~(propIn[i] ^ carryNet[i]);
      end else begin : gTrue
        assign railOut[i] = propIn[i] ^ carryNet[i];
      end
    end else begin : gOdd
      // OR-AND-invert: passes on the true carry.
      assign carryNet[i+1] = ~(~genIn[i] & (~propIn[i] | carryNet[i]));
      if (INV_RAIL) begin : gInv
        assign railOut[i] = propIn[i] ^ carryNet[i];
      end else begin : gTrue
        assign railOut[i] = ~(propIn[i] ^ carryNet[i]);
      end
    end
  end

  if ((WIDTH % 2) == 0) begin : gOutTrue
    assign carryOut = carryNet[WIDTH];
  end else begin : gOutInv
    assign carryOut = ~carryNet[WIDTH];
  end
endmodule

// File: rtl/sdAdderBlock.sv
module sdAdderBlock #(
  parameter int WIDTH = sdPkg::SD_DEF_WIDTH
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [WIDTH-1:0] propIn,
  output logic [WIDTH-1:0] sumOut,
  output logic [WIDTH-1:0] sumInvOut,
  output logic             carryOutA,
  output logic             carryOutB
);
  localparam int CHAINS = 2;

  logic [WIDTH-1:0] genTerm [CHAINS];
  logic [WIDTH-1:0] railVal [CHAINS];
  logic             carryVal[CHAINS];

  for (genvar k = 0; k < CHAINS; k++) begin : gChain
    sdGenStage #(.WIDTH(WIDTH)) i_gen (
      .opA    (opA),
      .opB    (opB),
      .genOut (genTerm[k])
    );
    sdRailChain #(.WIDTH(WIDTH), .INV_RAIL(k == 1)) i_chain (
      .propIn   (propIn),
      .genIn    (genTerm[k]),
      .railOut  (railVal[k]),
      .carryOut (carryVal[k])
    );
  end

  assign sumOut    = railVal[0];
  assign sumInvOut = railVal[1];
  assign carryOutA = carryVal[0];
  assign carryOutB = carryVal[1];

  always_comb begin
    AST_RAILS_COMPLEMENT: assert (sumInvOut == ~sumOut)
      else $error("rails not complementary");                     // R2
    AST_CARRY_COPIES_AGREE: assert (carryOutA == carryOutB)
      else $error("carry copies differ");                         // R3
    AST_LSB_NO_CARRYIN: assert (sumOut[0] == propIn[0])
      else $error("bit 0 sees a carry input");                    // R4
    if (propIn == (opA ^ opB)) begin
      AST_SUM_CORRECT: assert ({carryOutA, sumOut} == ({1'b0, opA} + {1'b0, opB}))
        else $error("arithmetic sum wrong");                      // R1
    end
    if ((&propIn) && ((opA & opB) == '0)) begin
      AST_ALL_PROPAGATE: assert ((&sumOut) && !carryOutA)
        else $error("all-propagate pattern wrong");               // R4
    end
  end
endmodule

// File: tb/test_sdAdderBlock.sv
module test_sdAdderBlock;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [31:0] a = '0, b = '0, p = '0;
  string curReq = "R4";
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [7:0]  s8, n8;
  logic        ca8, cb8;
  logic [11:0] s12, n12;
  logic        ca12, cb12;

  sdAdderBlock #(.WIDTH(8)) i_sdAdderBlock (
    .opA(a[7:0]), .opB(b[7:0]), .propIn(p[7:0]),
    .sumOut(s8), .sumInvOut(n8), .carryOutA(ca8), .carryOutB(cb8));

  sdAdderBlock #(.WIDTH(12)) i_sdAdderBlock12 (
    .opA(a[11:0]), .opB(b[11:0]), .propIn(p[11:0]),
    .sumOut(s12), .sumInvOut(n12), .carryOutA(ca12), .carryOutB(cb12));

  // Behavioural bit-serial reference: sum in [w-1:0], carry at [w].
  function automatic logic [32:0] refAdd(input int w, input logic [31:0] x,
                                         input logic [31:0] y, input logic [31:0] pr);
    logic c;
    logic [32:0] r;
    c = 1'b0;
    r = '0;
    for (int i = 0; i < w; i++) begin
      r[i] = pr[i] ^ c;
      c = (x[i] & y[i]) | (pr[i] & c);
    end
    r[w] = c;
    return r;
  endfunction

  task automatic checkSlice(input int w, input logic [31:0] sum, input logic [31:0] inv,
                            input logic cA, input logic cB);
    logic [32:0] exp;
    logic [31:0] m;
    m = 32'((64'd1 << w) - 1);
    exp = refAdd(w, a & m, b & m, p & m);
    total++;
    if ((sum & m) != (exp[31:0] & m) || cA != exp[w]) begin
      bad++;
      $display("FAIL %s w=%0d sum/carry got %h/%b exp %h/%b", curReq, w, sum & m, cA,
               exp[31:0] & m, exp[w]);
    end
    total++;
    if ((inv & m) != (~exp[31:0] & m)) begin
      bad++;
      $display("FAIL %s (R2) w=%0d inverted rail got %h exp %h", curReq, w, inv & m,
               ~exp[31:0] & m);
    end
    total++;
    if (cB != exp[w]) begin
      bad++;
      $display("FAIL %s (R3) w=%0d second carry got %b exp %b", curReq, w, cB, exp[w]);
    end
  endtask

  // Compare on every clock, away from the driving edge.
  always @(negedge clk) begin
    if (!finished) begin
      checkSlice(8, {24'd0, s8}, {24'd0, n8}, ca8, cb8);
      checkSlice(12, {20'd0, s12}, {20'd0, n12}, ca12, cb12);  // R7
    end
  end

  task automatic drive(input logic [31:0] x, input logic [31:0] y, input logic [31:0] pr,
                       input string tag);
    @(posedge clk);
    #1;
    a = x;
    b = y;
    p = pr;
    curReq = tag;
  endtask

  initial begin
    // Reset state: zero operands give zero sum, all-ones inverted rail.
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    // R1: consistent propagate, random operands.
    for (int n = 0; n < 40; n++) begin
      logic [31:0] x, y;
      x = $urandom;
      y = $urandom;
      drive(x, y, x ^ y, "R1");
    end
    // R4: all-propagate, no generate.
    drive(32'h0000_0F0F, 32'h0000_F0F0, 32'h0000_FFFF, "R4");
    drive(32'h0000_0AAA, 32'h0000_0555, 32'h0000_0FFF, "R4");
    // R6: full ripple from bit 0.
    drive(32'hFFFF_FFFF, 32'h1, 32'hFFFF_FFFE, "R6");
    drive(32'h0000_0FFF, 32'h0000_0FFF, 32'h0, "R6");
    // R5: propagate deliberately inconsistent with operands.
    for (int n = 0; n < 30; n++) begin
      drive($urandom, $urandom, $urandom, "R5");
    end
    drive(32'h0, 32'h0, 32'hFFFF_FFFF, "R5");
    // R2/R3: edge patterns.
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, "R3");
    drive(32'h0, 32'h0, 32'h0, "R2");
    @(posedge clk);
    #1 finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, got hang exp finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule